// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage integer pipeline whose stages run in the order fetch, decode/register read, execute, memory access and write-back. Each cycle the decode stage gives it the decoded instruction's source and destination register numbers, a write-enable and a load flag. The block keeps its own copy of those fields for the instructions now in execute, memory and write-back. From that copy it drives the operand bypass selects for the instruction in execute.

It also detects a load whose result is needed by the very next instruction. For that case it raises a one-cycle stall. The datapath uses the stall to hold the PC and the fetch/decode register and to put a no-op into execute; the block itself records that no-op as a bubble. Branches are predicted not taken and resolved at the end of decode. A mispredict that is not itself stalled raises a squash, which discards the one wrongly fetched instruction. A result in write-back needs no bypass when its consumer is in decode, because the register file writes in the first half of the cycle and reads in the second.

Top module: `hzd_unit`

## Requirements
- R1: When the instruction in memory access writes a non-zero register that the instruction in execute reads, that operand's select is 2'b10 (bypass from the memory stage).
- R2: When only the instruction in write-back writes a non-zero register that the instruction in execute reads, that operand's select is 2'b01 (bypass from the write-back stage). Otherwise the select is 2'b00 (register file).
- R3: When both later stages write the register an operand reads, the select is 2'b10.
- R4: A load in execute whose non-zero destination matches either source of the instruction in decode raises stall for exactly one cycle. The held consumer then gets select 2'b01 for that operand when it reaches execute.
- R5: A cycle with stall asserted sends a bubble into execute that writes no register, so the held instruction is never bypassed from a copy of itself.
- R6: squash equals br_mispredict in every cycle without stall, and is low in any cycle with stall.
- R7: Register 0 never produces a bypass select other than 2'b00 and never raises stall.
- R8: A producer three instructions ahead of its consumer, or one with its write-enable low, gives select 2'b00.
- R9: After reset, with idle decode inputs, both selects are 2'b00 and stall and squash are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_W | First source register of the instruction in decode |
| id_rs2 | input | REG_W | Second source register of the instruction in decode |
| id_rd | input | REG_W | Destination register of the instruction in decode |
| id_reg_we | input | 1 | Instruction in decode writes its destination |
| id_is_load | input | 1 | Instruction in decode is a load |
| br_mispredict | input | 1 | Branch in decode resolved taken (not-taken prediction wrong) |
| fwd_a | output | 2 | Operand A select for execute: 00 regfile, 01 write-back, 10 memory |
| fwd_b | output | 2 | Operand B select for execute, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register, bubble into execute |
| squash | output | 1 | Flush the instruction fetched after a mispredicted branch |

## Verification
The bench runs every producer distance from one to three against every choice of producer destination, consumer sources, write-enable and load flag over four registers. This exposes a design that bypasses from register 0, that stalls on a non-load, or that forwards a result three instructions old. Separate checks put matching writers in both later stages at once, which catches a priority inversion that would feed the older value. The load-use vectors give the consumer a destination equal to one of its own sources. A design that let the stalled instruction's fields leak into execute instead of a bubble would then bypass the consumer from a copy of itself. A mispredict raised in a stall cycle checks that squash is gated off there.

// File: rtl/hzd_pkg.sv
// Shared encodings for the hazard and forwarding unit.
// Assumes a two-bit select per ALU operand in the execute stage.
package hzd_pkg;
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_FROM_WB = 2'b01,
        SEL_FROM_MEM = 2'b10
    } byp_sel_e;
endpackage

// File: rtl/hzd_track.sv
// Shadow pipeline of register-use fields for execute, memory and write-back.
// Assumes the datapath advances every cycle; a stall turns the entry into
// execute into a bubble that writes nothing and is not a load.
module hzd_track #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_we,
    input  logic             id_ld,
    output logic [REG_W-1:0] ex_rs1,
    output logic [REG_W-1:0] ex_rs2,
    output logic [REG_W-1:0] ex_rd,
    output logic             ex_we,
    output logic             ex_ld,
    output logic [REG_W-1:0] mem_rd,
    output logic             mem_we,
    output logic             mem_ld,
    output logic [REG_W-1:0] wb_rd,
    output logic             wb_we
);
    // Advance the shadow fields one stage per cycle, bubbling on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_rs1 <= '0; ex_rs2 <= '0; ex_rd <= '0; ex_we <= 1'b0; ex_ld <= 1'b0;
            mem_rd <= '0; mem_we <= 1'b0; mem_ld <= 1'b0;
            wb_rd  <= '0; wb_we  <= 1'b0;
        end else begin
            ex_rs1 <= stall ? '0 : id_rs1;
            ex_rs2 <= stall ? '0 : id_rs2;
            ex_rd  <= stall ? '0 : id_rd;
            ex_we  <= stall ? 1'b0 : id_we;
            ex_ld  <= stall ? 1'b0 : id_ld;
            mem_rd <= ex_rd;
            mem_we <= ex_we;
            mem_ld <= ex_ld;
            wb_rd  <= mem_rd;
            wb_we  <= mem_we;
        end
    end

    // A bubble entering execute carries no write (R5).
    assert_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!ex_we && !ex_ld));
endmodule

// File: rtl/hzd_fwd.sv
// Bypass select for one execute-stage source operand.
// Assumes register 0 is hard-wired zero, so it is never bypassed.
module hzd_fwd #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rs,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output hzd_pkg::byp_sel_e sel
);
    import hzd_pkg::*;
    logic hit_mem, hit_wb;

    // Pick the youngest writer of this source; the memory stage wins.
    always_comb begin
        hit_mem = mem_we && (mem_rd != '0) && (mem_rd == rs);
        hit_wb  = wb_we  && (wb_rd  != '0) && (wb_rd  == rs);
        if (hit_mem)     sel = SEL_FROM_MEM;
        else if (hit_wb) sel = SEL_FROM_WB;
        else             sel = SEL_REGFILE;
    end

    assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11);
    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rs == '0) |-> (sel == SEL_REGFILE));
endmodule

// File: rtl/hzd_stall.sv
// Load-use interlock: a load in execute feeding the instruction in decode.
// Assumes load data is only available at the end of the memory stage.
module hzd_stall #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_ld,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    output logic             stall
);
    // Raise the interlock when either decode source needs the load result.
    always_comb begin
        stall = ex_ld && (ex_rd != '0) && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    end
endmodule

// File: rtl/hzd_unit.sv
// Hazard and forwarding unit for a five-stage pipeline.
// Tracks register use of execute, memory and write-back, emits per-operand
// bypass selects, a one-cycle load-use stall, and a branch squash.
// Assumes a write-before-read register file, so write-back to decode needs
// no bypass, and branches resolved in decode under not-taken prediction.
module hzd_unit #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_reg_we,
    input  logic             id_is_load,
    input  logic             br_mispredict,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             stall,
    output logic             squash
);
    import hzd_pkg::*;

    logic [REG_W-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic             ex_we, ex_ld, mem_we, mem_ld, wb_we;
    logic [REG_W-1:0] src [N_SRC];
    byp_sel_e         sel [N_SRC];

    hzd_stall #(.REG_W(REG_W)) u_stall (
        .ex_rd(ex_rd), .ex_ld(ex_ld), .id_rs1(id_rs1), .id_rs2(id_rs2), .stall(stall)
    );

    hzd_track #(.REG_W(REG_W)) u_track (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
        .id_we(id_reg_we), .id_ld(id_is_load),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_ld(mem_ld),
        .wb_rd(wb_rd), .wb_we(wb_we)
    );

    // Gather execute-stage sources into an array for the per-operand units.
    always_comb begin
        src[0] = ex_rs1;
        src[1] = ex_rs2;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        hzd_fwd #(.REG_W(REG_W)) u_fwd (
            .clk(clk), .rst_n(rst_n), .rs(src[g]),
            .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
            .sel(sel[g])
        );
    end

    // Drive outputs; a stalled branch decision is not yet valid.
    always_comb begin
        fwd_a  = sel[0];
        fwd_b  = sel[1];
        squash = br_mispredict && !stall;
    end

    assert_stall_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    assert_no_load_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_a == SEL_FROM_MEM) || (fwd_b == SEL_FROM_MEM)) |-> !mem_ld);
    assert_squash_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !squash);
endmodule

// File: tb/hzd_unit_test.sv
`timescale 1ns/1ps
module hzd_unit_test;
    localparam int RW = 5;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic id_reg_we = 1'b0, id_is_load = 1'b0, br_mispredict = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic stall, squash;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hzd_unit #(.REG_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
        .id_reg_we(id_reg_we), .id_is_load(id_is_load), .br_mispredict(br_mispredict),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .squash(squash)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one decoded instruction after the falling edge, let logic settle.
    task automatic drive(input int r1, input int r2, input int rd, input bit we, input bit ld);
        @(negedge clk);
        id_rs1 = RW'(r1); id_rs2 = RW'(r2); id_rd = RW'(rd);
        id_reg_we = we; id_is_load = ld;
        #1;
    endtask

    task automatic hold();
        @(negedge clk);
        #1;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 1'b0, 1'b0);
    endtask

    function automatic int exp_sel(int rs, int prd, bit we, bit ld, int d);
        if (rs == 0 || !we || rs != prd) return 0;
        if (d == 1) return ld ? 1 : 2;
        if (d == 2) return 1;
        return 0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check("R9 fwd_a", fwd_a, 0);
        check("R9 fwd_b", fwd_b, 0);
        check("R9 stall", stall, 0);
        check("R9 squash", squash, 0);

        // Sweep: producer distance, destination, write/load flags, consumer sources.
        for (int d = 1; d <= 3; d++)
        for (int prd = 0; prd < 4; prd++)
        for (int we = 0; we < 2; we++)
        for (int ld = 0; ld < 2; ld++)
        for (int r1 = 0; r1 < 4; r1++)
        for (int r2 = 0; r2 < 4; r2++) begin
            bit est;
            if (ld && !we) continue;
            flush();
            drive(7, 7, prd, we[0], ld[0]);
            for (int f = 1; f < d; f++) drive(0, 0, 0, 1'b0, 1'b0);
            // Consumer also writes its second source, exposing a missing bubble (R5).
            drive(r1, r2, r2, 1'b1, 1'b0);
            est = (d == 1) && ld && prd != 0 && (prd == r1 || prd == r2);
            check(prd == 0 ? "R7 stall" : "R4 stall", stall, int'(est));
            if (est) begin
                hold();
                check("R4 stall released", stall, 0);
            end
            drive(0, 0, 0, 1'b0, 1'b0);
            // R1 R2 R8 R5 bypass selects for the consumer now in execute
            check(d == 3 ? "R8 fwd_a" : (est ? "R5 fwd_a" : "R1/R2 fwd_a"),
                  fwd_a, exp_sel(r1, prd, we[0], ld[0], d));
            check(d == 3 ? "R8 fwd_b" : (est ? "R5 fwd_b" : "R1/R2 fwd_b"),
                  fwd_b, exp_sel(r2, prd, we[0], ld[0], d));
        end

        // R3: both later stages write register 4, memory stage wins.
        flush();
        drive(0, 0, 4, 1'b1, 1'b0);
        drive(0, 0, 4, 1'b1, 1'b0);
        drive(4, 4, 0, 1'b0, 1'b0);
        drive(0, 0, 0, 1'b0, 1'b0);
        check("R3 fwd_a", fwd_a, 2);
        check("R3 fwd_b", fwd_b, 2);

        // R3: mixed, memory stage writes 5, write-back writes 6.
        flush();
        drive(0, 0, 6, 1'b1, 1'b0);
        drive(0, 0, 5, 1'b1, 1'b0);
        drive(6, 5, 0, 1'b0, 1'b0);
        drive(0, 0, 0, 1'b0, 1'b0);
        check("R3 fwd_a mixed", fwd_a, 1);
        check("R3 fwd_b mixed", fwd_b, 2);

        // R6: mispredict without stall squashes.
        flush();
        drive(1, 2, 3, 1'b1, 1'b0);
        br_mispredict = 1'b1; #1;
        check("R6 squash", squash, 1);
        br_mispredict = 1'b0; #1;
        check("R6 squash idle", squash, 0);

        // R6: mispredict during a load-use stall is held off.
        flush();
        drive(0, 0, 3, 1'b1, 1'b1);
        drive(3, 0, 0, 1'b0, 1'b0);
        br_mispredict = 1'b1; #1;
        check("R6 stall", stall, 1);
        check("R6 squash gated", squash, 0);
        hold();
        check("R6 squash after stall", squash, 1);
        br_mispredict = 1'b0;
        flush();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule